// File: doc/BRIEF.md
# Nested Vectored Interrupt Priority Unit

This block tracks nested interrupt service for a processor. Sixteen vector slots each hold a 32-bit handler address and a small control field. The control field binds the slot to one of 32 interrupt sources and switches the slot on or off. Slot 0 has the highest priority. A default handler address serves the unvectored level that sits below all slots. There is also an idle level, so the unit has eighteen levels: 0 to 15 for the slots, 16 for the unvectored level and 17 for idle.

From the slot bindings the unit builds, for every level, a mask of the sources owned by slots of higher priority. The interrupt request output is gated by the mask of the level that is currently being served. A neighbouring block supplies two inputs: the combined raw pending vector (hardware and software) and the per-source IRQ eligibility, which is the enable gated with the IRQ/FIQ routing.

Software reads the vector register at the entry of a handler. That read returns the handler address and moves the unit into the level of the highest-priority pending slot, remembering the level it left. Software writes the vector register at the exit of the handler. That write returns the unit to the remembered level. All accesses go through a plain 32-bit register port with a one-cycle-latency registered read.

Top module: `vecprio_unit`

## Requirements
- R1: After reset every slot address, every slot control and the default address read back as 0, and the unit is idle (level 17).
- R2: Slot k's address is at byte offset 0x100+4k and its control at 0x200+4k. The default address is at 0x034. A control write keeps data bits 5:0, where bit 5 is the slot enable and bits 4:0 give the source number. Reads return the stored value zero-extended one cycle after the strobe.
- R3: The mask of level L is the OR of one-hot(source) over the enabled slots numbered below L. Level 16 covers every enabled slot, and idle level 17 is all ones. irqOut = OR(rawPend & irqElig & mask[current level]).
- R4: A read of the vector register at 0x030 finds the lowest level i below the current level for which rawPend & mask[i+1] is nonzero. The unit saves the current level as the previous level of i, makes i current and returns the address of level i. Level 16 returns the default address.
- R5: A vector read at idle with nothing pending returns the default address, and the unit stays idle.
- R6: A vector read that finds no level below the current one returns the address of the current level and leaves the level unchanged.
- R7: A write to 0x030 ignores its data. When the unit is not idle, the write restores the level saved for the current level. When the unit is idle, the write has no effect.
- R8: A control write changes the masks and irqOut on the cycle right after the strobe.
- R9: The side effects of an access happen once per strobe, on the first cycle of busSel. Holding busSel high does not repeat them.
- R10: Reads of unmapped offsets return 0. Writes to unmapped offsets change no stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Access strobe; the rising edge starts one access |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte offset of the access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, registered |
| rawPend | input | 32 | Raw pending sources (hardware OR software) |
| irqElig | input | 32 | Per-source IRQ eligibility (enabled and routed to IRQ) |
| irqOut | output | 1 | Interrupt request |

## Verification
A wrong current level shows on irqOut in the same cycle: the mask of the wrong level either lets through a lower-priority source or blocks one that should pass. It also shows on the next vector read as a wrong handler address. A corrupted saved-level history stays hidden until the matching exit write; after that write, irqOut and the next vector read show the error. The bench therefore keeps a reference model of the level and of the history, and compares irqOut on every step and the read data on every read. It runs a random mix of entry reads and exit writes deep enough to unwind nested levels.

// File: rtl/vecprio_pkg.sv
package vecprio_pkg;
  localparam logic [11:0] VP_SLOT_ADDR_BASE = 12'h100;
  localparam logic [11:0] VP_SLOT_CTRL_BASE = 12'h200;
  localparam logic [11:0] VP_VECTOR_OFS     = 12'h030;
  localparam logic [11:0] VP_DEFAULT_OFS    = 12'h034;

  typedef enum logic [2:0] {
    RD_NONE, RD_SLOT_ADDR, RD_SLOT_CTRL, RD_VECTOR, RD_DEFAULT
  } vp_rdkind_e;

  typedef struct packed {
    logic       wrSlotAddr;
    logic       wrSlotCtrl;
    logic       wrDefault;
    logic       ackVec;
    logic       rdVec;
    logic       rdLoad;
    vp_rdkind_e rdKind;
  } vp_strobe_t;
endpackage

// File: rtl/vecprio_ctrl.sv
module vecprio_ctrl
  import vecprio_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output vp_strobe_t        stb,
  output logic [SLOT_W-1:0] slotIdx
);
  localparam int HI = ADDR_W - 1;
  localparam int LO = 2 + SLOT_W;
  localparam logic [ADDR_W-1:0] ADDR_BASE = ADDR_W'(VP_SLOT_ADDR_BASE);
  localparam logic [ADDR_W-1:0] CTRL_BASE = ADDR_W'(VP_SLOT_CTRL_BASE);
  localparam logic [ADDR_W-1:0] VEC_OFS   = ADDR_W'(VP_VECTOR_OFS);
  localparam logic [ADDR_W-1:0] DEF_OFS   = ADDR_W'(VP_DEFAULT_OFS);

  logic selQ;
  logic fire;
  logic inAddrWin, inCtrlWin, isVec, isDef;

  always_ff @(posedge clk) begin
    if (!rstN) selQ <= 1'b0;
    else       selQ <= busSel;
  end

  assign fire      = busSel && !selQ;
  assign inAddrWin = (busAddr[HI:LO] == ADDR_BASE[HI:LO]);
  assign inCtrlWin = (busAddr[HI:LO] == CTRL_BASE[HI:LO]);
  assign isVec     = (busAddr[HI:2] == VEC_OFS[HI:2]);
  assign isDef     = (busAddr[HI:2] == DEF_OFS[HI:2]);
  assign slotIdx   = busAddr[2 +: SLOT_W];

  always_comb begin
    stb = '0;
    stb.rdKind = RD_NONE;
    if (fire) begin
      if (busWr) begin
        stb.wrSlotAddr = inAddrWin;
        stb.wrSlotCtrl = inCtrlWin;
        stb.wrDefault  = isDef;
        stb.ackVec     = isVec;
      end else begin
        stb.rdLoad = 1'b1;
        stb.rdVec  = isVec;
        if (inAddrWin)      stb.rdKind = RD_SLOT_ADDR;
        else if (inCtrlWin) stb.rdKind = RD_SLOT_CTRL;
        else if (isVec)     stb.rdKind = RD_VECTOR;
        else if (isDef)     stb.rdKind = RD_DEFAULT;
      end
    end
  end

  // R9: at most one side-effect strobe per cycle
  p_single_strobe_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrSlotAddr, stb.wrSlotCtrl, stb.wrDefault, stb.ackVec, stb.rdVec}));
  // R9: a held select never produces back-to-back vector reads
  p_vec_once_r9: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdVec |=> !stb.rdVec);
  // R9: any strobe needs busSel to have been low on the previous cycle
  p_edge_only_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && $past(busSel) && $past(rstN)) |-> !stb.rdLoad);
endmodule

// File: rtl/vecprio_datapath.sv
module vecprio_datapath
  import vecprio_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int NUM_SRC   = 32,
  parameter int DATA_W    = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  vp_strobe_t                   stb,
  input  logic [$clog2(NUM_SLOTS)-1:0] slotIdx,
  input  logic [DATA_W-1:0]            busWdata,
  input  logic [NUM_SRC-1:0]           rawPend,
  input  logic [NUM_SRC-1:0]           irqElig,
  output logic [DATA_W-1:0]            busRdata,
  output logic                         irqOut
);
  localparam int SRC_W   = $clog2(NUM_SRC);
  localparam int CTRL_W  = SRC_W + 1;
  localparam int DEF_LVL = NUM_SLOTS;
  localparam int IDLE    = NUM_SLOTS + 1;
  localparam int LVL_W   = $clog2(NUM_SLOTS + 2);
  localparam logic [LVL_W-1:0] IDLE_L = LVL_W'(IDLE);

  logic [DATA_W-1:0]  slotAddr [NUM_SLOTS];
  logic [CTRL_W-1:0]  slotCtrl [NUM_SLOTS];
  logic [DATA_W-1:0]  defAddr;
  logic [LVL_W-1:0]   curLvl;
  logic [LVL_W-1:0]   prevLvl [NUM_SLOTS+1];
  logic [NUM_SRC-1:0] lvlMask [NUM_SLOTS+2];
  logic [NUM_SLOTS:0] hit;
  logic [LVL_W-1:0]   found;

  // Per-level masks: a ripple OR chain over the slots in priority order.
  assign lvlMask[0] = '0;
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_mask
    logic [NUM_SRC-1:0] own;
    assign own = slotCtrl[s][SRC_W] ? (NUM_SRC'(1) << slotCtrl[s][SRC_W-1:0]) : '0;
    if (s == NUM_SLOTS - 1) begin : g_last
      assign lvlMask[s+1] = lvlMask[s] | own;
      assign lvlMask[IDLE] = '1;
    end else begin : g_mid
      assign lvlMask[s+1] = lvlMask[s] | own;
    end
  end

  for (genvar i = 0; i <= NUM_SLOTS; i++) begin : g_hit
    assign hit[i] = |(rawPend & lvlMask[i+1]);
  end

  // Lowest level below the current one that has a pending claim.
  always_comb begin
    found = curLvl;
    for (int i = NUM_SLOTS; i >= 0; i--) begin
      if (LVL_W'(i) < curLvl && hit[i]) found = LVL_W'(i);
    end
  end

  function automatic logic [DATA_W-1:0] lvlAddr(input logic [LVL_W-1:0] l);
    logic [DATA_W-1:0] a;
    a = defAddr;
    for (int k = 0; k < NUM_SLOTS; k++) if (l == LVL_W'(k)) a = slotAddr[k];
    return a;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < NUM_SLOTS; k++) begin
        slotAddr[k] <= '0;
        slotCtrl[k] <= '0;
      end
      for (int k = 0; k <= NUM_SLOTS; k++) prevLvl[k] <= IDLE_L;
      defAddr  <= '0;
      curLvl   <= IDLE_L;
      busRdata <= '0;
    end else begin
      if (stb.wrSlotAddr) slotAddr[slotIdx] <= busWdata;
      if (stb.wrSlotCtrl) slotCtrl[slotIdx] <= busWdata[CTRL_W-1:0];
      if (stb.wrDefault)  defAddr <= busWdata;
      if (stb.ackVec && curLvl != IDLE_L) curLvl <= prevLvl[curLvl];
      if (stb.rdVec && found < curLvl) begin
        prevLvl[found] <= curLvl;
        curLvl         <= found;
      end
      if (stb.rdLoad) begin
        unique case (stb.rdKind)
          RD_SLOT_ADDR: busRdata <= slotAddr[slotIdx];
          RD_SLOT_CTRL: busRdata <= DATA_W'(slotCtrl[slotIdx]);
          RD_DEFAULT:   busRdata <= defAddr;
          RD_VECTOR:    busRdata <= (found < curLvl) ? lvlAddr(found) :
                                    (curLvl == IDLE_L) ? defAddr : lvlAddr(curLvl);
          default:      busRdata <= '0;
        endcase
      end
    end
  end

  assign irqOut = |(rawPend & irqElig & lvlMask[curLvl]);

  // R4: the level never leaves 0..IDLE
  p_level_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    curLvl <= IDLE_L);
  // R4: an entry read can only move to a higher priority (lower number)
  p_enter_up_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdVec |=> curLvl <= $past(curLvl));
  // R4: without an entry read or an exit write the level holds
  p_level_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.rdVec && !stb.ackVec) |=> $stable(curLvl));
  // R7: an exit write at idle leaves the unit idle
  p_idle_ack_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ackVec && curLvl == IDLE_L) |=> curLvl == IDLE_L);
  // R3: at level 0 nothing may interrupt
  p_level0_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    (curLvl == '0) |-> !irqOut);
  // R3: at idle every eligible pending source raises the request
  p_idle_open_r3: assert property (@(posedge clk) disable iff (!rstN)
    (curLvl == IDLE_L) |-> (irqOut == |(rawPend & irqElig)));
endmodule

// File: rtl/vecprio_unit.sv
module vecprio_unit
  import vecprio_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int NUM_SRC   = 32,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [NUM_SRC-1:0] rawPend,
  input  logic [NUM_SRC-1:0] irqElig,
  output logic              irqOut
);
  localparam int SLOT_W = $clog2(NUM_SLOTS);

  vp_strobe_t        stb;
  logic [SLOT_W-1:0] slotIdx;

  vecprio_ctrl #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .stb(stb), .slotIdx(slotIdx)
  );

  vecprio_datapath #(.NUM_SLOTS(NUM_SLOTS), .NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .slotIdx(slotIdx), .busWdata(busWdata),
    .rawPend(rawPend), .irqElig(irqElig), .busRdata(busRdata), .irqOut(irqOut)
  );
endmodule

// File: tb/sim_vecprio_unit.sv
module sim_vecprio_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rstN = 0, busSel = 0, busWr = 0, irqOut;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0, busRdata, rawPend = '0, irqElig = '0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vecprio_unit u0 (.clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .rawPend(rawPend), .irqElig(irqElig), .irqOut(irqOut));

  // Reference model
  logic [31:0] mAddr [16];
  logic [5:0]  mCtrl [16];
  logic [31:0] mDef;
  int mCur;
  int mPrev [17];

  function automatic logic [31:0] mMask(int l);
    logic [31:0] m = '0;
    if (l == 17) return '1;
    for (int s = 0; s < l; s++) if (mCtrl[s][5]) m |= 32'd1 << mCtrl[s][4:0];
    return m;
  endfunction

  function automatic logic [31:0] mLvlAddr(int l);
    return (l < 16) ? mAddr[l] : mDef;
  endfunction

  function automatic logic mIrq();
    return |(rawPend & irqElig & mMask(mCur));
  endfunction

  function automatic logic [31:0] mVecRead();
    int f = mCur;
    for (int i = 0; i < mCur; i++) if ((rawPend & mMask(i+1)) != 0) begin f = i; break; end
    if (f < mCur) begin mPrev[f] = mCur; mCur = f; return mLvlAddr(f); end
    if (mCur == 17) return mDef;
    return mLvlAddr(mCur);
  endfunction

  function automatic void mWrite(logic [11:0] a, logic [31:0] d);
    if (a >= 12'h100 && a < 12'h140) mAddr[a[5:2]] = d;
    else if (a >= 12'h200 && a < 12'h240) mCtrl[a[5:2]] = d[5:0];
    else if (a == 12'h034) mDef = d;
    else if (a == 12'h030 && mCur < 17) mCur = mPrev[mCur];
  endfunction

  function automatic logic [31:0] mRead(logic [11:0] a);
    if (a >= 12'h100 && a < 12'h140) return mAddr[a[5:2]];
    if (a >= 12'h200 && a < 12'h240) return {26'd0, mCtrl[a[5:2]]};
    if (a == 12'h034) return mDef;
    if (a == 12'h030) return mVecRead();
    return '0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [11:0] a, logic [31:0] d);
    @(negedge clk); busSel = 1; busWr = 1; busAddr = a; busWdata = d;
    @(negedge clk); busSel = 0; busWr = 0;
    mWrite(a, d);
  endtask

  task automatic busRead(logic [11:0] a, output logic [31:0] d, output logic [31:0] e);
    e = mRead(a);
    @(negedge clk); busSel = 1; busWr = 0; busAddr = a;
    @(negedge clk); busSel = 0;
    d = busRdata;
  endtask

  task automatic rdChk(string req, logic [11:0] a);
    logic [31:0] d, e;
    busRead(a, d, e);
    chk(req, d, e);
  endtask

  task automatic irqChk(string req);
    chk(req, {31'd0, irqOut}, {31'd0, mIrq()});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog all-requirements actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    for (int k = 0; k < 16; k++) begin mAddr[k] = '0; mCtrl[k] = '0; end
    for (int k = 0; k < 17; k++) mPrev[k] = 17;
    mDef = '0; mCur = 17;
    repeat (3) @(negedge clk);
    rstN = 1;

    // R1: reset contents and idle level
    rdChk("R1 slot addr", 12'h10C);
    rdChk("R1 slot ctrl", 12'h21C);
    rdChk("R1 default", 12'h034);
    rdChk("R5 vector read idle nothing pending", 12'h030);
    rawPend = 32'h1; irqElig = 32'h1;
    #1 irqChk("R1 idle passes any eligible");

    // R2: programming map and readback width
    rawPend = '0;
    busWrite(12'h100, 32'hA000_0000);
    busWrite(12'h104, 32'hA000_0104);
    busWrite(12'h034, 32'hDEF0_0000);
    busWrite(12'h200, 32'hFFFF_FF25);
    busWrite(12'h204, 32'h0000_0023);
    rdChk("R2 ctrl keeps bits 5:0", 12'h200);
    rdChk("R2 slot1 addr", 12'h104);
    rdChk("R2 default readback", 12'h034);

    // R10: unmapped offsets
    busWrite(12'h038, 32'h1234_5678);
    rdChk("R10 unmapped read zero", 12'h038);
    rdChk("R10 unmapped write left default", 12'h034);

    // R3/R4: nesting; slot0 serves source 5, slot1 source 3
    irqElig = '1; rawPend = 32'h8;
    #1 irqChk("R3 idle irq");
    rdChk("R4 enter slot1", 12'h030);
    #1 irqChk("R3 level1 blocks own source");
    rdChk("R6 no higher pending keeps level", 12'h030);
    rawPend = 32'h28;
    #1 irqChk("R3 level1 passes source 5");
    rdChk("R4 enter slot0", 12'h030);
    #1 irqChk("R3 level0 quiet");
    busWrite(12'h030, 32'hFFFF_FFFF);
    #1 irqChk("R7 restore to level1");
    busWrite(12'h030, 32'h0);
    #1 irqChk("R7 restore to idle");
    rawPend = 32'h0; irqElig = '0;
    busWrite(12'h030, 32'h0);
    rawPend = 32'h200;
    rdChk("R7 idle ack no effect; R4 unvectored enters default", 12'h030);
    #1 irqChk("R3 level16 blocks unclaimed source");
    busWrite(12'h030, 32'h0);

    // R8: control write visible next cycle
    irqElig = '1; rawPend = 32'h8;
    rdChk("R4 enter slot1 again", 12'h030);
    rawPend = 32'h20;
    #1 irqChk("R8 before disable");
    busWrite(12'h200, 32'h0);
    chk("R8 disable slot0 drops irq", {31'd0, irqOut}, 32'd0);
    busWrite(12'h200, 32'h25);
    busWrite(12'h030, 32'h0);

    // R9: held select fires once; source 5 appears mid-hold
    rawPend = 32'h8;
    begin
      logic [31:0] e;
      e = mVecRead();
      @(negedge clk); busSel = 1; busWr = 0; busAddr = 12'h030;
      @(negedge clk); rawPend = 32'h28;
      @(negedge clk);
      @(negedge clk); busSel = 0;
      chk("R9 held read data", busRdata, e);
      chk("R9 held read level once", {31'd0, irqOut}, {31'd0, mIrq()});
    end
    busWrite(12'h030, 32'h0);

    // Random mix
    for (int it = 0; it < 600; it++) begin
      int op;
      logic [3:0] sl;
      rawPend = $urandom & $urandom & 32'h0000_00FF;
      irqElig = $urandom | $urandom;
      op = int'($urandom % 6);
      sl = 4'($urandom);
      case (op)
        0, 1: rdChk("R4 random vector read", 12'h030);
        2: busWrite(12'h030, $urandom);
        3: busWrite({8'h20, sl, 2'b00}, {26'd0, 1'($urandom), 5'($urandom % 8)});
        4: busWrite({8'h10, sl, 2'b00}, $urandom);
        default: rdChk("R2 random ctrl read", {8'h20, sl, 2'b00});
      endcase
      #1 irqChk("R3 random irq");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule